// File: doc/BRIEF.md
# Keypad Controller Command Register Port

This block is the slave-side command decoder of a keypad and GPIO controller. It sits behind a byte-stream serial link and sees only three kinds of event: a start marker, a written byte and a request for a read byte. Bit timing on the wire is handled elsewhere. After each start, the first written byte is taken as the command code. Every later written byte is a parameter, numbered from zero. Read requests are answered from whichever command code was latched last.

The block holds the controller's configuration registers: configuration, interrupt status, scan active time, debounce time, keypad size, clock setup, GPIO pull, direction and level, and a sticky error register. It also holds a small script memory and the start/stop requests for three PWM lines. Each command checks its own parameters and records faults in the error register. When a write command has taken its final parameter, the command slot is locked to the marker 0xFF, so any extra byte is reported as a fault.

The written-byte stream uses valid/ready. `wr_ready` is low only in a cycle where `bus_start` is high, so a byte offered together with a start waits one cycle. The read-request stream also uses valid/ready. `rq_ready` is low while `bus_start` or `wr_valid` is high, so a written byte takes priority over a read request. The response is a one-cycle `rsp_valid` pulse with no back-pressure. The host must take it in the cycle after its request was accepted.

Top module: `kpc_cmd_port`

## Requirements
- R1: A start clears the byte count. The first byte written after it is latched as the command, and later written bytes are parameters 0, 1, 2 and so on. `wr_ready` is low while `bus_start` is high. Each accepted read request gives exactly one `rsp_valid` pulse in the next cycle.
- R2: When a write command takes its final parameter, the command slot becomes 0xFF. Any data byte written while 0xFF is latched sets error bit 0 (bad parameter).
- R3: An unrecognised code sets error bit 1 (unknown command), and a read of it returns 0x00. Unrecognised codes include a write to a read-only code, a read of a write-only code, and a read while 0xFF is latched.
- R4: Setting any error bit also sets status bit 3. Error bits stay set until the hardware reset. `irq_n` is low whenever the status byte is non-zero. Error read 0x8C returns the error byte.
- R5: The hardware reset and the command 0x83 with parameter 0xAA both load config 0x80, status 0x10, active time 125, debounce 3, keypad size 0x33 and clock 0x08. The hardware reset also clears the errors and the GPIO registers; 0x83 leaves them unchanged. 0x83 with any other parameter sets bad parameter and changes no register.
- R6: The GPIO writes are 0x84 for pull, 0x85 for direction and 0x86 for level. Parameter 0 loads the low byte and clears the high byte. Parameter 1 ORs in the high byte and completes the command. Read 0x87 (direction) and read 0x88 (level) return the low byte at read index 0, the high byte at index 1, and 0x00 after that.
- R7: Keypad size write 0x90 stores its value. It sets bad parameter when the low nibble is outside 3..12 or the high nibble is outside 3..8. Read 0x91 returns the stored value.
- R8: Active-time write 0x8B and debounce write 0x8F store their value and drive it on `scan_active` and `scan_debounce`. A debounce of 0 is still stored but sets bad parameter.
- R9: Clock write 0x93 stores its value. It sets bad parameter when bits [1:0] are 01 or 10. Read 0x94 returns (clock AND 0xFC) OR 0x02.
- R10: Config write 0x81 stores its value and clears the status byte. Read 0x92 returns the low nibble of the config. Status read 0x82 returns the status and then clears it, unless status bit 4 (not initialised) is set.
- R11: ID read 0x80 returns 0x00 at read index 0, 0x04 at index 1, and 0x00 after that.
- R12: Script write 0x95 takes an address byte A, a high byte and a low byte, and stores {high, low} at entry A. An A with bits [1:0] = 00 or A[7:2] > 59 sets bad parameter and ends the command. A valid A zeroes its entry at once. `script_rdata` shows the entry at `script_raddr` one cycle later.
- R13: Line start 0x96 with value V raises `pwm_go` bit (V[1:0]-1) for one cycle and drives `pwm_entry` = V[7:2]. Line stop 0x97 raises `pwm_halt` bit (V[1:0]-1) for one cycle. A start V that fails the R12 address rule, or a stop with V[1:0] = 00, sets bad parameter. Both commands complete after one parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start event; clears the byte count |
| wr_valid | input | 1 | Written byte offered |
| wr_ready | output | 1 | Written byte accepted |
| wr_data | input | 8 | Written byte |
| rq_valid | input | 1 | Read byte requested |
| rq_ready | output | 1 | Read request accepted |
| rsp_valid | output | 1 | Read byte valid (one cycle) |
| rsp_data | output | 8 | Read byte |
| irq_n | output | 1 | Low while any status bit is set |
| scan_active | output | 8 | Active-time register |
| scan_debounce | output | 8 | Debounce register |
| gpio_pull | output | 16 | GPIO pull select |
| gpio_dir | output | 16 | GPIO direction |
| gpio_level | output | 16 | GPIO level |
| pwm_go | output | 3 | One-cycle start pulse per PWM line |
| pwm_halt | output | 3 | One-cycle stop pulse per PWM line |
| pwm_entry | output | 6 | Script entry for the last start |
| script_raddr | input | 8 | Script read address |
| script_rdata | output | 16 | Script entry, registered |

## Verification
A written byte takes effect at the clock edge that accepts it. The register outputs, the error bits and `irq_n` change there, and `pwm_go`/`pwm_halt` pulse for exactly the cycle that follows that edge. The bench samples all of these on the falling edge just after the accepting edge. A read response arrives one cycle after its request: the driver pushes the expected byte and its requirement tag into a queue when it raises the request, and a monitor pops and compares the byte at the falling edge where `rsp_valid` is high. The script port is sampled one full cycle after the address is set. Pulse outputs are checked again one cycle later to confirm they have dropped.

// File: rtl/kpc_pkg.sv
package kpc_pkg;
  typedef logic [7:0] byte_t;

  // command codes
  localparam byte_t CMD_ID_RD    = 8'h80;
  localparam byte_t CMD_CFG_WR   = 8'h81;
  localparam byte_t CMD_INT_RD   = 8'h82;
  localparam byte_t CMD_RESET    = 8'h83;
  localparam byte_t CMD_PULL_WR  = 8'h84;
  localparam byte_t CMD_DIR_WR   = 8'h85;
  localparam byte_t CMD_LVL_WR   = 8'h86;
  localparam byte_t CMD_DIR_RD   = 8'h87;
  localparam byte_t CMD_LVL_RD   = 8'h88;
  localparam byte_t CMD_ACT_WR   = 8'h8B;
  localparam byte_t CMD_ERR_RD   = 8'h8C;
  localparam byte_t CMD_DBN_WR   = 8'h8F;
  localparam byte_t CMD_KSZ_WR   = 8'h90;
  localparam byte_t CMD_KSZ_RD   = 8'h91;
  localparam byte_t CMD_CFG_RD   = 8'h92;
  localparam byte_t CMD_CLK_WR   = 8'h93;
  localparam byte_t CMD_CLK_RD   = 8'h94;
  localparam byte_t CMD_SCR_WR   = 8'h95;
  localparam byte_t CMD_LINE_GO  = 8'h96;
  localparam byte_t CMD_LINE_END = 8'h97;
  localparam byte_t CMD_LOCKED   = 8'hFF;

  localparam byte_t RESET_KEY    = 8'hAA;
  localparam logic [15:0] CHIP_ID = 16'h0400;

  // defaults
  localparam byte_t DEF_CFG = 8'h80;
  localparam byte_t DEF_ST  = 8'h10;
  localparam byte_t DEF_ACT = 8'd125;
  localparam byte_t DEF_DBN = 8'd3;
  localparam byte_t DEF_KSZ = 8'h33;
  localparam byte_t DEF_CLK = 8'h08;

  // bit positions
  localparam int ERR_PARAM  = 0;
  localparam int ERR_UNKNOWN = 1;
  localparam int ST_ERR     = 3;
  localparam int ST_NOINIT  = 4;

  // limits
  localparam int KEY_MIN      = 3;
  localparam int KEY_ROWS_MAX = 12;
  localparam int KEY_COLS_MAX = 8;
  localparam int SCRIPT_LAST  = 59;
endpackage

// File: rtl/kpc_byte_seq.sv
module kpc_byte_seq
  import kpc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             wr_fire,
  input  logic [7:0]       wr_data,
  input  logic             rd_fire,
  input  logic             lock,
  output logic [7:0]       cmd_q,
  output logic             is_param,
  output logic [CNT_W-1:0] param_idx,
  output logic [CNT_W-1:0] rd_idx
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     cnt_q <= '0;
    else if (bus_start)                             cnt_q <= '0;
    else if ((wr_fire || rd_fire) && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cmd_q <= CMD_LOCKED;
    else if (wr_fire && cnt_q == '0) cmd_q <= wr_data;
    else if (lock)                   cmd_q <= CMD_LOCKED;
  end

  assign is_param  = wr_fire && (cnt_q != '0);
  assign param_idx = cnt_q - 1'b1;
  assign rd_idx    = cnt_q;

  // R2: a completed write leaves the lock marker in the command slot
  p_lock_marks_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> cmd_q == CMD_LOCKED);
  // R1: a start always returns the count to zero
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (rd_idx == '0));
endmodule

// File: rtl/kpc_script_store.sv
module kpc_script_store
  import kpc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LINES = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cmd,
  input  logic             is_param,
  input  logic [CNT_W-1:0] param_idx,
  input  logic [7:0]       wdata,
  input  logic [AW-1:0]    raddr,
  output logic [15:0]      rdata,
  output logic [LINES-1:0] go,
  output logic [LINES-1:0] halt,
  output logic [5:0]       entry,
  output logic             bad,
  output logic             done
);
  localparam int DEPTH = 1 << AW;

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] faddr_q;
  logic [7:0]    hi_q;
  logic          sel_wr, sel_go, sel_end, addr_ok, we;
  logic [AW-1:0] waddr;
  logic [15:0]   wval;

  assign sel_wr  = is_param && cmd == CMD_SCR_WR;
  assign sel_go  = is_param && cmd == CMD_LINE_GO;
  assign sel_end = is_param && cmd == CMD_LINE_END;
  assign addr_ok = (wdata[1:0] != 2'b00) && (int'(wdata[7:2]) <= SCRIPT_LAST);

  always_comb begin
    bad   = 1'b0;
    done  = 1'b0;
    we    = 1'b0;
    waddr = faddr_q;
    wval  = 16'h0000;
    if (sel_wr) begin
      if (param_idx == '0) begin
        waddr = AW'(wdata);
        we    = addr_ok;
        bad   = !addr_ok;
        done  = !addr_ok;
      end else if (param_idx == CNT_W'(1)) begin
        we   = 1'b1;
        wval = {wdata, 8'h00};
      end else begin
        we   = 1'b1;
        wval = {hi_q, wdata};
        done = 1'b1;
      end
    end
    if (sel_go) begin
      bad  = !addr_ok;
      done = 1'b1;
    end
    if (sel_end) begin
      bad  = (wdata[1:0] == 2'b00);
      done = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wval;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= '0;
      hi_q    <= '0;
      entry   <= '0;
    end else begin
      if (sel_wr && param_idx == '0 && addr_ok) faddr_q <= AW'(wdata);
      if (sel_wr && param_idx == CNT_W'(1))     hi_q    <= wdata;
      if (sel_go && addr_ok)                    entry   <= wdata[7:2];
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        go[g]   <= 1'b0;
        halt[g] <= 1'b0;
      end else begin
        go[g]   <= sel_go && addr_ok && (int'(wdata[1:0]) == g + 1);
        halt[g] <= sel_end && (int'(wdata[1:0]) == g + 1);
      end
    end
  end

  // R13: at most one line pulses, and a start never points past the script
  p_go_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go));
  p_halt_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(halt));
  p_entry_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|go) |-> (int'(entry) <= SCRIPT_LAST));
endmodule

// File: rtl/kpc_ctrl_regs.sv
module kpc_ctrl_regs
  import kpc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cmd,
  input  logic             is_param,
  input  logic [CNT_W-1:0] param_idx,
  input  logic [7:0]       wdata,
  input  logic             rd_fire,
  input  logic [CNT_W-1:0] rd_idx,
  input  logic             scr_bad,
  input  logic             scr_done,
  output logic             lock,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output logic             irq_n,
  output logic [7:0]       act,
  output logic [7:0]       dbn,
  output logic [15:0]      pull,
  output logic [15:0]      dir,
  output logic [15:0]      lvl
);
  logic [7:0]  cfg_q, st_q, ksz_q, clk_q, err_q;
  logic [7:0]  cfg_n, st_n, act_n, dbn_n, ksz_n, clk_n, err_n, rdata;
  logic [15:0] pull_n, dir_n, lvl_n;
  logic        bad, unk;
  logic [3:0]  k_lo, k_hi;

  assign k_lo = wdata[3:0];
  assign k_hi = wdata[7:4];

  always_comb begin
    cfg_n = cfg_q; st_n = st_q; act_n = act; dbn_n = dbn;
    ksz_n = ksz_q; clk_n = clk_q; pull_n = pull; dir_n = dir; lvl_n = lvl;
    bad = 1'b0; unk = 1'b0; lock = 1'b0; rdata = 8'h00;
    if (is_param) begin
      case (cmd)
        CMD_CFG_WR: begin cfg_n = wdata; st_n = 8'h00; lock = 1'b1; end
        CMD_RESET: begin
          lock = 1'b1;
          if (wdata == RESET_KEY) begin
            cfg_n = DEF_CFG; st_n = DEF_ST; act_n = DEF_ACT;
            dbn_n = DEF_DBN; ksz_n = DEF_KSZ; clk_n = DEF_CLK;
          end else bad = 1'b1;
        end
        CMD_PULL_WR: begin
          if (param_idx == '0) pull_n = {8'h00, wdata};
          else begin pull_n = pull | {wdata, 8'h00}; lock = 1'b1; end
        end
        CMD_DIR_WR: begin
          if (param_idx == '0) dir_n = {8'h00, wdata};
          else begin dir_n = dir | {wdata, 8'h00}; lock = 1'b1; end
        end
        CMD_LVL_WR: begin
          if (param_idx == '0) lvl_n = {8'h00, wdata};
          else begin lvl_n = lvl | {wdata, 8'h00}; lock = 1'b1; end
        end
        CMD_ACT_WR: begin act_n = wdata; lock = 1'b1; end
        CMD_DBN_WR: begin dbn_n = wdata; lock = 1'b1; bad = (wdata == 8'h00); end
        CMD_KSZ_WR: begin
          ksz_n = wdata; lock = 1'b1;
          bad = (int'(k_lo) < KEY_MIN) || (int'(k_lo) > KEY_ROWS_MAX) ||
                (int'(k_hi) < KEY_MIN) || (int'(k_hi) > KEY_COLS_MAX);
        end
        CMD_CLK_WR: begin
          clk_n = wdata; lock = 1'b1;
          bad = (wdata[1:0] == 2'b01) || (wdata[1:0] == 2'b10);
        end
        CMD_SCR_WR, CMD_LINE_GO, CMD_LINE_END: begin bad = scr_bad; lock = scr_done; end
        CMD_LOCKED: bad = 1'b1;
        default:    unk = 1'b1;
      endcase
    end
    if (rd_fire) begin
      case (cmd)
        CMD_ID_RD: rdata = (rd_idx == '0) ? CHIP_ID[7:0] :
                           (rd_idx == CNT_W'(1)) ? CHIP_ID[15:8] : 8'h00;
        CMD_INT_RD: begin
          rdata = (rd_idx == '0) ? st_q : 8'h00;
          if (!st_q[ST_NOINIT]) st_n = 8'h00;
        end
        CMD_DIR_RD: rdata = (rd_idx == '0) ? dir[7:0] : (rd_idx == CNT_W'(1)) ? dir[15:8] : 8'h00;
        CMD_LVL_RD: rdata = (rd_idx == '0) ? lvl[7:0] : (rd_idx == CNT_W'(1)) ? lvl[15:8] : 8'h00;
        CMD_ERR_RD: rdata = err_q;
        CMD_KSZ_RD: rdata = ksz_q;
        CMD_CFG_RD: rdata = {4'h0, cfg_q[3:0]};
        CMD_CLK_RD: rdata = (clk_q & 8'hFC) | 8'h02;
        default:    unk = 1'b1;
      endcase
    end
    err_n = err_q;
    err_n[ERR_PARAM]   = err_q[ERR_PARAM] | bad;
    err_n[ERR_UNKNOWN] = err_q[ERR_UNKNOWN] | unk;
    if (bad || unk) st_n[ST_ERR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= DEF_CFG; st_q <= DEF_ST; act <= DEF_ACT; dbn <= DEF_DBN;
      ksz_q <= DEF_KSZ; clk_q <= DEF_CLK; err_q <= 8'h00;
      pull <= '0; dir <= '0; lvl <= '0;
      rsp_valid <= 1'b0; rsp_data <= 8'h00;
    end else begin
      cfg_q <= cfg_n; st_q <= st_n; act <= act_n; dbn <= dbn_n;
      ksz_q <= ksz_n; clk_q <= clk_n; err_q <= err_n;
      pull <= pull_n; dir <= dir_n; lvl <= lvl_n;
      rsp_valid <= rd_fire; rsp_data <= rdata;
    end
  end

  assign irq_n = (st_q == 8'h00);

  // R4: a newly set error bit always brings the error status flag
  p_err_flags_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_q & ~$past(err_q))) |-> st_q[ST_ERR]);
  // R4: error bits never clear without the hardware reset
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & $past(err_q)) == $past(err_q)));
  // R2: a byte into a locked slot is a bad parameter
  p_locked_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_param && cmd == CMD_LOCKED) |=> err_q[ERR_PARAM]);
  // R3: reading with the locked marker is an unknown command and yields zero
  p_unknown_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && cmd == CMD_LOCKED) |=> (err_q[ERR_UNKNOWN] && rsp_data == 8'h00));
  // R1: one response per accepted request, one cycle later
  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);
endmodule

// File: rtl/kpc_cmd_port.sv
module kpc_cmd_port
  import kpc_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SCRIPT_AW = 8,
  parameter int PWM_LINES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_start,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [7:0]           wr_data,
  input  logic                 rq_valid,
  output logic                 rq_ready,
  output logic                 rsp_valid,
  output logic [7:0]           rsp_data,
  output logic                 irq_n,
  output logic [7:0]           scan_active,
  output logic [7:0]           scan_debounce,
  output logic [15:0]          gpio_pull,
  output logic [15:0]          gpio_dir,
  output logic [15:0]          gpio_level,
  output logic [PWM_LINES-1:0] pwm_go,
  output logic [PWM_LINES-1:0] pwm_halt,
  output logic [5:0]           pwm_entry,
  input  logic [SCRIPT_AW-1:0] script_raddr,
  output logic [15:0]          script_rdata
);
  logic             wr_fire, rd_fire, lock, is_param, scr_bad, scr_done;
  logic [7:0]       cmd;
  logic [CNT_W-1:0] param_idx, rd_idx;

  assign wr_ready = !bus_start;
  assign rq_ready = !bus_start && !wr_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rq_valid && rq_ready;

  kpc_byte_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .wr_fire(wr_fire),
    .wr_data(wr_data), .rd_fire(rd_fire), .lock(lock), .cmd_q(cmd),
    .is_param(is_param), .param_idx(param_idx), .rd_idx(rd_idx)
  );

  kpc_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .is_param(is_param),
    .param_idx(param_idx), .wdata(wr_data), .rd_fire(rd_fire), .rd_idx(rd_idx),
    .scr_bad(scr_bad), .scr_done(scr_done), .lock(lock),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_n(irq_n),
    .act(scan_active), .dbn(scan_debounce), .pull(gpio_pull),
    .dir(gpio_dir), .lvl(gpio_level)
  );

  kpc_script_store #(.AW(SCRIPT_AW), .LINES(PWM_LINES), .CNT_W(CNT_W)) u_script (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .is_param(is_param),
    .param_idx(param_idx), .wdata(wr_data), .raddr(script_raddr),
    .rdata(script_rdata), .go(pwm_go), .halt(pwm_halt), .entry(pwm_entry),
    .bad(scr_bad), .done(scr_done)
  );
endmodule

// File: tb/test_kpc_cmd_port.sv
module test_kpc_cmd_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0, wr_valid = 1'b0, rq_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  script_raddr = 8'h00;
  logic        wr_ready, rq_ready, rsp_valid, irq_n;
  logic [7:0]  rsp_data, scan_active, scan_debounce;
  logic [15:0] gpio_pull, gpio_dir, gpio_level, script_rdata;
  logic [2:0]  pwm_go, pwm_halt;
  logic [5:0]  pwm_entry;

  int total = 0, bad = 0, n_req = 0, n_rsp = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  kpc_cmd_port i_kpc_cmd_port (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .irq_n(irq_n), .scan_active(scan_active), .scan_debounce(scan_debounce),
    .gpio_pull(gpio_pull), .gpio_dir(gpio_dir), .gpio_level(gpio_level),
    .pwm_go(pwm_go), .pwm_halt(pwm_halt), .pwm_entry(pwm_entry),
    .script_raddr(script_raddr), .script_rdata(script_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares each response with the scoreboard head
  always @(negedge clk) begin
    if (rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0) chk("R1 unexpected response", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rsp_data, e);
      end
    end
  end

  task automatic start_ev();
    bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic get(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t); n_req++;
    rq_valid = 1'b1;
    @(negedge clk);
    rq_valid = 1'b0;
  endtask

  task automatic w1(input logic [7:0] c, input logic [7:0] p);
    start_ev(); put(c); put(p);
  endtask

  task automatic w2(input logic [7:0] c, input logic [7:0] p0, input logic [7:0] p1);
    start_ev(); put(c); put(p0); put(p1);
  endtask

  task automatic rd1(input logic [7:0] c, input logic [7:0] e, input string t);
    start_ev(); put(c); start_ev(); get(e, t);
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fresh();   // reset and clear the not-initialised status
    hw_reset(); w1(8'h81, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk("R5 irq_n at reset", irq_n, 0);
    chk("R5 active default", scan_active, 125);
    chk("R5 debounce default", scan_debounce, 3);
    chk("R5 gpio dir default", gpio_dir, 0);
    rd1(8'h82, 8'h10, "R10 status not-init kept");
    rd1(8'h82, 8'h10, "R10 status not cleared");
    rd1(8'h91, 8'h33, "R5 keypad size default");
    rd1(8'h92, 8'h00, "R10 config low nibble");
    rd1(8'h94, 8'h0A, "R9 clock readback default");
    rd1(8'h8C, 8'h00, "R4 no errors");
    start_ev(); put(8'h80); start_ev();
    get(8'h00, "R11 id byte0"); get(8'h04, "R11 id byte1"); get(8'h00, "R11 id byte2");
    // R1 ready rules
    bus_start = 1'b1; wr_valid = 1'b1; #1;
    chk("R1 wr_ready low on start", wr_ready, 0);
    chk("R1 rq_ready low on start", rq_ready, 0);
    @(negedge clk); bus_start = 1'b0; wr_valid = 1'b0;
    // R10 config
    w1(8'h81, 8'h05);
    chk("R10 config clears status", irq_n, 1);
    rd1(8'h92, 8'h05, "R10 config read");
    rd1(8'h82, 8'h00, "R10 status zero");
    // R6 gpio
    w2(8'h85, 8'h34, 8'h12);
    chk("R6 dir value", gpio_dir, 16'h1234);
    start_ev(); put(8'h87); start_ev();
    get(8'h34, "R6 dir low"); get(8'h12, "R6 dir high"); get(8'h00, "R6 dir beyond");
    w2(8'h86, 8'hCD, 8'hAB);
    chk("R6 level value", gpio_level, 16'hABCD);
    start_ev(); put(8'h88); start_ev();
    get(8'hCD, "R6 level low"); get(8'hAB, "R6 level high");
    w2(8'h84, 8'h11, 8'h22);
    chk("R6 pull value", gpio_pull, 16'h2211);
    w1(8'h85, 8'h77);
    chk("R6 low byte clears high", gpio_dir, 16'h0077);
    rd1(8'h8C, 8'h00, "R6 no error from gpio");
    // R2 lock
    w2(8'h8B, 8'h40, 8'h99);
    chk("R8 active stored", scan_active, 8'h40);
    chk("R4 irq after error", irq_n, 0);
    rd1(8'h8C, 8'h01, "R2 extra byte bad param");
    rd1(8'h82, 8'h08, "R4 status error flag");
    rd1(8'h82, 8'h00, "R10 status cleared by read");
    chk("R4 irq released", irq_n, 1);
    rd1(8'h8C, 8'h01, "R4 error sticky");
    // R3 unknown
    fresh();
    rd1(8'h8B, 8'h00, "R3 read of write-only code");
    rd1(8'h8C, 8'h02, "R3 unknown flagged on read");
    fresh();
    w1(8'h8C, 8'h00);
    rd1(8'h8C, 8'h02, "R3 write to read-only code");
    fresh();
    start_ev(); put(8'h8B); put(8'h01); start_ev();
    get(8'h00, "R3 read while locked");
    rd1(8'h8C, 8'h02, "R3 locked read is unknown");
    // R7 keypad size
    fresh(); w1(8'h90, 8'h2C);
    rd1(8'h8C, 8'h01, "R7 high nibble 2 bad");
    rd1(8'h91, 8'h2C, "R7 stored anyway");
    fresh(); w1(8'h90, 8'h8C);
    rd1(8'h8C, 8'h00, "R7 8x12 boundary ok");
    fresh(); w1(8'h90, 8'h93);
    rd1(8'h8C, 8'h01, "R7 high nibble 9 bad");
    fresh(); w1(8'h90, 8'h3D);
    rd1(8'h8C, 8'h01, "R7 low nibble 13 bad");
    // R8 debounce
    fresh(); w1(8'h8F, 8'h00);
    chk("R8 zero debounce stored", scan_debounce, 0);
    rd1(8'h8C, 8'h01, "R8 zero debounce bad");
    fresh(); w1(8'h8F, 8'h01);
    rd1(8'h8C, 8'h00, "R8 debounce 1 ok");
    // R9 clock
    fresh(); w1(8'h93, 8'h07);
    rd1(8'h8C, 8'h00, "R9 clock 11 ok");
    rd1(8'h94, 8'h06, "R9 clock readback");
    fresh(); w1(8'h93, 8'h01);
    rd1(8'h8C, 8'h01, "R9 clock 01 bad");
    rd1(8'h94, 8'h02, "R9 clock readback 01");
    // R5 reset command
    fresh();
    w2(8'h85, 8'h21, 8'h43); w1(8'h8B, 8'h10); w1(8'h90, 8'h44); w1(8'h81, 8'h0F);
    w1(8'h83, 8'h55);
    rd1(8'h91, 8'h44, "R5 bad key keeps size");
    rd1(8'h8C, 8'h01, "R5 bad key flagged");
    w1(8'h83, 8'hAA);
    chk("R5 cmd reset status", irq_n, 0);
    chk("R5 cmd reset active", scan_active, 125);
    chk("R5 cmd reset keeps gpio", gpio_dir, 16'h4321);
    rd1(8'h91, 8'h33, "R5 cmd reset size");
    rd1(8'h92, 8'h00, "R5 cmd reset config");
    rd1(8'h8C, 8'h01, "R5 cmd reset keeps errors");
    hw_reset();
    rd1(8'h8C, 8'h00, "R5 hw reset clears errors");
    // R12 script
    fresh();
    start_ev(); put(8'h95); put(8'h05); put(8'hBE); put(8'hEF);
    script_raddr = 8'h05; @(negedge clk);
    chk("R12 script entry 5", script_rdata, 16'hBEEF);
    start_ev(); put(8'h95); put(8'hEF); put(8'h12); put(8'h34);
    script_raddr = 8'hEF; @(negedge clk);
    chk("R12 last entry", script_rdata, 16'h1234);
    rd1(8'h8C, 8'h00, "R12 valid writes no error");
    w1(8'h95, 8'h05); script_raddr = 8'h05; @(negedge clk);
    chk("R12 address byte zeroes entry", script_rdata, 0);
    fresh(); w1(8'h95, 8'hF1);
    rd1(8'h8C, 8'h01, "R12 address 60 bad");
    fresh(); w1(8'h95, 8'h04);
    rd1(8'h8C, 8'h01, "R12 line bits 00 bad");
    // R13 line start/stop
    fresh(); w1(8'h96, 8'h0A);
    chk("R13 go line index 1", pwm_go, 3'b010);
    chk("R13 go entry", pwm_entry, 2);
    @(negedge clk);
    chk("R13 go one cycle", pwm_go, 0);
    w1(8'h96, 8'h0B);
    chk("R13 go line index 2", pwm_go, 3'b100);
    w1(8'h97, 8'h01);
    chk("R13 halt line index 0", pwm_halt, 3'b001);
    rd1(8'h8C, 8'h00, "R13 valid start/stop no error");
    w1(8'h97, 8'h00);
    chk("R13 bad stop no pulse", pwm_halt, 0);
    rd1(8'h8C, 8'h01, "R13 stop bits 00 bad");
    fresh(); w1(8'h96, 8'hF0);
    chk("R13 bad start no pulse", pwm_go, 0);
    rd1(8'h8C, 8'h01, "R13 start bits 00 bad");
    repeat (3) @(negedge clk);
    chk("R1 one response per request", n_rsp, n_req);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule